// File: doc/BRIEF.md
# DRAM Fast Page Mode Controller

This block sits between a processor-side request port and a 16-bit DRAM data path. Each request names one 16-bit word by its byte address, says whether it is a read or a write, and for writes carries the data and two byte enables. The controller turns each request into RAS, CAS and write-enable sequences on a multiplexed row/column address bus, and returns read data together with a one-cycle completion pulse.

The first access after the page is closed is a full five-phase cycle. Q1 is the RAS-high phase with the row driven. Q2 and Q3 drop RAS on the row. Q4 and Q5 drive the column. When the next request arrives during Q5 and names the same row, RAS stays low and the follow-on access uses only a Q4/Q5 column pair. A burst of same-row words therefore costs two clocks each.

A static input selects one of two strobe styles. In the first, a single CAS is shared by both lanes and each lane has its own write enable. In the second, each lane has its own CAS and a single write enable is shared.

The sequencer is a state machine with six states: `ST_IDLE`, `ST_Q1`, `ST_Q2`, `ST_Q3`, `ST_Q4` and `ST_Q5`. Its transitions are named as follows:
- IDLE→IDLE when no request is present.
- IDLE→Q1 when a request is taken.
- Q1→Q2, Q2→Q3, Q3→Q4 and Q4→Q5 unconditionally.
- Q5→Q4 on a same-row request (page hit).
- Q5→Q1 on a different-row request (page miss).
- Q5→IDLE when no request is present, which closes the page.

Top module: `fpm_ctrl`

## Requirements
- R1: After reset, and in `ST_IDLE`, the outputs are at rest: `ras_n`=1, `cas_n`=2'b11, `we_n`=2'b11, `dq_oe`=0, `dram_addr`=0, `done`=0 and `req_ready`=1.
- R2: A request taken in `ST_IDLE` starts a full cycle on the next clock. The cycle runs one clock per phase:
  - Q1: `ras_n`=1 with the row on `dram_addr`.
  - Q2 and Q3: `ras_n`=0 with the row held.
  - Q4 and Q5: `ras_n`=0 with the column driven.
- R3: A request present during Q5 whose row equals the row of the access in progress is a page hit. The next clock is Q4 of the new access with the new column, and `ras_n` stays 0 with no gap.
- R4: A request present during Q5 with a different row goes to Q1, which raises RAS for one clock. No request during Q5 returns the controller to `ST_IDLE` with RAS high, so the next access is a full cycle even when it names the same row.
- R5: `cas_n` is 2'b11 in every phase except Q5 and is never low while `ras_n` is 1. A request is taken only in a cycle where `req_ready`=1, which is exactly `ST_IDLE` and Q5.
- R6: With `cfg_two_cas`=0, both `cas_n` bits go low together in Q5. For a write, `we_n[i]`=0 during Q4 and Q5 for each lane with `req_be[i]`=1, and 1 otherwise. For a read, `we_n`=2'b11.
- R7: With `cfg_two_cas`=1, a write drives `we_n`=2'b00 during Q4 and Q5, and in Q5 sets `cas_n[i]`=0 only for lanes with `req_be[i]`=1. A read drives both `cas_n` bits low in Q5 with `we_n`=2'b11, whatever `req_be` holds.
- R8: During Q4 and Q5 of a write, `dq_oe`=1 and `dq_out` carries the write word. Bits 15..8 are the even-address byte, which travels on device data bits 31..24, and bits 7..0 are the odd byte, on bits 23..16. At all other times `dq_oe`=0, and `we_n` is 2'b11 whenever `dq_oe`=0.
- R9: For a read, `dq_in` is sampled at the end of Q5 and appears on `rd_data` in the following cycle. It holds there until the next read completes, and writes do not change it.
- R10: `done` is high for exactly one clock, the clock after each Q5, for reads and writes alike.
- R11: The column is `req_addr[COL_W:1]` and the row is `req_addr[ADDR_W-1:COL_W+1]`. Address bit 0 is ignored, so consecutive words (byte address +2) step the column by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_two_cas | input | 1 | Static strobe style: 0 = shared CAS with per-lane WE, 1 = per-lane CAS with shared WE |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Write byte enables: [1] even byte, [0] odd byte |
| req_addr | input | ADDR_W (19) | Byte address of the word |
| req_wdata | input | 16 | Write word: [15:8] even byte, [7:0] odd byte |
| req_ready | output | 1 | Request taken this cycle if valid |
| rd_data | output | 16 | Last read word |
| done | output | 1 | One-clock completion pulse |
| dram_addr | output | MA_W (9) | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Column strobes, active low: [1] even lane, [0] odd lane |
| we_n | output | 2 | Write enables, active low: [1] even lane, [0] odd lane |
| dq_out | output | 16 | Write data: [15:8] device bits 31..24, [7:0] device bits 23..16 |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 16 | Read data from the device lanes |

## Verification
Two things can happen in the same cycle. The completion pulse and captured read data of one access can coincide with the Q4 column phase of the next page-hit access. Likewise, taking a new request can coincide with the CAS strobe of the current one in Q5. Both are provoked by queueing same-row words with no gap between them, and by mixing reads and writes in that burst. A behavioural model in the bench predicts every pin on every clock, so a slipped pulse, a late column or a spurious RAS rise in that overlap is judged as a miscompare.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_Q1   = 3'd1,
        ST_Q2   = 3'd2,
        ST_Q3   = 3'd3,
        ST_Q4   = 3'd4,
        ST_Q5   = 3'd5
    } fpm_state_e;
endpackage

// File: rtl/fpm_req_reg.sv
module fpm_req_reg #(
    parameter int ROW_W = 9,
    parameter int COL_W = 9,
    localparam int ADDR_W = ROW_W + COL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_write,
    input  logic [1:0]        in_be,
    input  logic [15:0]       in_wdata,
    output logic [ROW_W-1:0]  r_row,
    output logic [COL_W-1:0]  r_col,
    output logic              r_write,
    output logic [1:0]        r_be,
    output logic [15:0]       r_wdata,
    output logic              page_hit
);
    logic [ROW_W-1:0] in_row;
    logic [COL_W-1:0] in_col;

    // address bit 0 selects a byte inside the word and is dropped
    assign in_col   = in_addr[COL_W:1];
    assign in_row   = in_addr[ADDR_W-1:COL_W+1];
    // the latched row is the row held open while RAS is low
    assign page_hit = (in_row == r_row);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_row   <= '0;
            r_col   <= '0;
            r_write <= 1'b0;
            r_be    <= 2'b00;
            r_wdata <= '0;
        end else if (take) begin
            r_row   <= in_row;
            r_col   <= in_col;
            r_write <= in_write;
            r_be    <= in_be;
            r_wdata <= in_wdata;
        end
    end
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
    import fpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       page_hit,
    output fpm_state_e state,
    output logic       take,
    output logic       ready,
    output logic       done
);
    fpm_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= (state == ST_Q5);
        end
    end

    always_comb begin
        nxt   = state;
        ready = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ready = 1'b1;
                nxt   = req_valid ? ST_Q1 : ST_IDLE;
            end
            ST_Q1: nxt = ST_Q2;
            ST_Q2: nxt = ST_Q3;
            ST_Q3: nxt = ST_Q4;
            ST_Q4: nxt = ST_Q5;
            ST_Q5: begin
                ready = 1'b1;
                if (!req_valid)    nxt = ST_IDLE;
                else if (page_hit) nxt = ST_Q4;
                else               nxt = ST_Q1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign take = ready && req_valid;
endmodule

// File: rtl/fpm_strobe.sv
module fpm_strobe
    import fpm_pkg::*;
#(
    parameter int ROW_W = 9,
    parameter int COL_W = 9,
    localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  fpm_state_e       state,
    input  logic             cfg_two_cas,
    input  logic [ROW_W-1:0] r_row,
    input  logic [COL_W-1:0] r_col,
    input  logic             r_write,
    input  logic [1:0]       r_be,
    input  logic [15:0]      r_wdata,
    output logic [MA_W-1:0]  dram_addr,
    output logic             ras_n,
    output logic [1:0]       cas_n,
    output logic [1:0]       we_n,
    output logic [15:0]      dq_out,
    output logic             dq_oe
);
    logic [1:0] we_write;
    logic [1:0] cas_col;

    // lane qualification for the two strobe styles
    assign we_write = cfg_two_cas ? 2'b00 : ~r_be;
    assign cas_col  = (cfg_two_cas && r_write) ? ~r_be : 2'b00;

    always_comb begin
        dram_addr = '0;
        ras_n     = 1'b1;
        cas_n     = 2'b11;
        we_n      = 2'b11;
        dq_out    = '0;
        dq_oe     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_Q1: dram_addr = MA_W'(r_row);
            ST_Q2, ST_Q3: begin
                dram_addr = MA_W'(r_row);
                ras_n     = 1'b0;
            end
            ST_Q4, ST_Q5: begin
                dram_addr = MA_W'(r_col);
                ras_n     = 1'b0;
                if (r_write) begin
                    we_n   = we_write;
                    dq_out = r_wdata;
                    dq_oe  = 1'b1;
                end
                if (state == ST_Q5) cas_n = cas_col;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W = 9,
    parameter int COL_W = 9,
    localparam int ADDR_W = ROW_W + COL_W + 1,
    localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_two_cas,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_be,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic              req_ready,
    output logic [15:0]       rd_data,
    output logic              done,
    output logic [MA_W-1:0]   dram_addr,
    output logic              ras_n,
    output logic [1:0]        cas_n,
    output logic [1:0]        we_n,
    output logic [15:0]       dq_out,
    output logic              dq_oe,
    input  logic [15:0]       dq_in
);
    fpm_state_e       state;
    logic             take;
    logic             page_hit;
    logic [ROW_W-1:0] r_row;
    logic [COL_W-1:0] r_col;
    logic             r_write;
    logic [1:0]       r_be;
    logic [15:0]      r_wdata;

    fpm_req_reg #(.ROW_W(ROW_W), .COL_W(COL_W)) u_req (
        .clk(clk), .rst_n(rst_n), .take(take),
        .in_addr(req_addr), .in_write(req_write), .in_be(req_be), .in_wdata(req_wdata),
        .r_row(r_row), .r_col(r_col), .r_write(r_write), .r_be(r_be), .r_wdata(r_wdata),
        .page_hit(page_hit)
    );

    fpm_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .page_hit(page_hit),
        .state(state), .take(take), .ready(req_ready), .done(done)
    );

    fpm_strobe #(.ROW_W(ROW_W), .COL_W(COL_W)) u_strb (
        .state(state), .cfg_two_cas(cfg_two_cas),
        .r_row(r_row), .r_col(r_col), .r_write(r_write), .r_be(r_be), .r_wdata(r_wdata),
        .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // read capture at the end of the CAS phase
    always_ff @(posedge clk) begin
        if (!rst_n)                          rd_data <= '0;
        else if (state == ST_Q5 && !r_write) rd_data <= dq_in;
    end
endmodule

// File: rtl/fpm_ctrl_chk.sv
module fpm_ctrl_chk #(
    parameter int MA_W = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_two_cas,
    input logic            ras_n,
    input logic [1:0]      cas_n,
    input logic [1:0]      we_n,
    input logic [MA_W-1:0] dram_addr,
    input logic            dq_oe,
    input logic            done
);
    assert_cas_needs_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n != 2'b11) |-> !ras_n);

    assert_row_held_at_ras_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $stable(dram_addr));

    assert_col_held_at_cas_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_n != 2'b11) |-> $stable(dram_addr));

    assert_shared_cas_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_two_cas |-> (cas_n[0] == cas_n[1]));

    assert_shared_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_two_cas |-> (we_n[0] == we_n[1]));

    assert_we_only_when_driving_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (we_n == 2'b11));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_cas_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(cas_n) != 2'b11));
endmodule

bind fpm_ctrl fpm_ctrl_chk #(.MA_W(MA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_two_cas(cfg_two_cas), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .dram_addr(dram_addr), .dq_oe(dq_oe), .done(done)
);

// File: tb/fpm_ctrl_test.sv
module fpm_ctrl_test;
    localparam int ROW_W = 9;
    localparam int COL_W = 9;
    localparam int ADDR_W = ROW_W + COL_W + 1;
    localparam int MA_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_two_cas = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [1:0] req_be = 2'b00;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic req_ready, done, ras_n, dq_oe;
    logic [15:0] rd_data, dq_out, dq_in;
    logic [MA_W-1:0] dram_addr;
    logic [1:0] cas_n, we_n;

    always #5 clk = ~clk;

    // device model: read word is a fixed function of the address pins
    assign dq_in = {dram_addr[7:0] ^ 8'hA5, ~dram_addr[7:0]};

    fpm_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_two_cas(cfg_two_cas),
        .req_valid(req_valid), .req_write(req_write), .req_be(req_be),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_data(rd_data), .done(done), .dram_addr(dram_addr), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    typedef struct {
        int          row;
        int          col;
        bit          b0;
        bit          wr;
        logic [1:0]  be;
        logic [15:0] d;
        int          gap;
    } stim_t;

    stim_t q[$];
    int vectors = 0;
    int errors = 0;
    int cyc = 0;

    int m_phase = 0;
    stim_t m_req;
    bit m_done = 0;
    logic [15:0] m_rd = '0;

    function automatic logic [15:0] dev_word(int col);
        logic [7:0] a = 8'(col);
        return {a ^ 8'hA5, ~a};
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d %s got %h expected %h", rq, cyc, what, got, exp);
        end
    endtask

    task automatic push(input int row, input int col, input bit b0, input bit wr,
                        input logic [1:0] be, input logic [15:0] d, input int gap);
        stim_t s;
        s.row = row; s.col = col; s.b0 = b0; s.wr = wr; s.be = be; s.d = d; s.gap = gap;
        q.push_back(s);
    endtask

    task automatic compare_all();
        logic e_ras; logic [1:0] e_cas, e_we; logic [MA_W-1:0] e_addr;
        logic e_oe; logic [15:0] e_dout; logic e_rdy;
        e_ras = 1'b1; e_cas = 2'b11; e_we = 2'b11; e_addr = '0; e_oe = 1'b0; e_dout = '0;
        e_rdy = (m_phase == 0 || m_phase == 5);
        if (m_phase >= 1 && m_phase <= 3) e_addr = MA_W'(m_req.row);
        if (m_phase >= 2) e_ras = 1'b0;
        if (m_phase >= 4) begin
            e_addr = MA_W'(m_req.col);
            if (m_req.wr) begin
                e_oe = 1'b1; e_dout = m_req.d;
                e_we = cfg_two_cas ? 2'b00 : ~m_req.be;
            end
            if (m_phase == 5)
                e_cas = (cfg_two_cas && m_req.wr) ? ~m_req.be : 2'b00;
        end
        chk("R2", "ras_n", 32'(ras_n), 32'(e_ras));
        chk("R11", "dram_addr", 32'(dram_addr), 32'(e_addr));
        chk(cfg_two_cas ? "R7" : "R6", "cas_n", 32'(cas_n), 32'(e_cas));
        chk(cfg_two_cas ? "R7" : "R6", "we_n", 32'(we_n), 32'(e_we));
        chk("R8", "dq_oe", 32'(dq_oe), 32'(e_oe));
        if (e_oe) chk("R8", "dq_out", 32'(dq_out), 32'(e_dout));
        chk("R5", "req_ready", 32'(req_ready), 32'(e_rdy));
        chk("R10", "done", 32'(done), 32'(m_done));
        chk("R9", "rd_data", 32'(rd_data), 32'(m_rd));
    endtask

    task automatic step();
        bit v; stim_t h; bit acc;
        @(negedge clk);
        cyc++;
        compare_all();
        v = 0;
        if (q.size() > 0) begin
            if ((m_phase == 0 || m_phase == 5) && q[0].gap > 0) q[0].gap--;
            else if (q[0].gap == 0) v = 1;
        end
        req_valid = v;
        if (v) begin
            h = q[0];
            req_write = h.wr; req_be = h.be; req_wdata = h.d;
            req_addr = ADDR_W'((h.row << (COL_W + 1)) | (h.col << 1) | int'(h.b0));
        end else begin
            req_write = 1'b0; req_be = 2'b00; req_wdata = '0; req_addr = '0;
        end
        acc = v && (m_phase == 0 || m_phase == 5);
        m_done = (m_phase == 5);
        if (m_phase == 5 && !m_req.wr) m_rd = dev_word(m_req.col);
        case (m_phase)
            0: m_phase = acc ? 1 : 0;
            5: m_phase = !acc ? 0 : ((h.row == m_req.row) ? 4 : 1);
            default: m_phase = m_phase + 1;
        endcase
        if (acc) begin
            m_req = h;
            void'(q.pop_front());
        end
    endtask

    task automatic drain();
        while (q.size() > 0 || m_phase != 0) step();
        repeat (3) step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: rest state while in reset
        chk("R1", "ras_n", 32'(ras_n), 32'd1);
        chk("R1", "cas_n", 32'(cas_n), 32'd3);
        chk("R1", "we_n", 32'(we_n), 32'd3);
        chk("R1", "dq_oe", 32'(dq_oe), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "req_ready", 32'(req_ready), 32'd1);
        chk("R1", "dram_addr", 32'(dram_addr), 32'd0);
        rst_n = 1'b1;
        repeat (2) step();

        // shared-CAS style: R3 read burst, columns stepping by one word (R11)
        push(3, 0, 0, 0, 2'b00, 16'h0, 0);
        push(3, 1, 0, 0, 2'b01, 16'h0, 0);
        push(3, 2, 0, 0, 2'b00, 16'h0, 0);
        push(3, 3, 0, 0, 2'b00, 16'h0, 0);
        // R6 writes inside the same page with each byte-enable pattern
        push(3, 4, 0, 1, 2'b11, 16'h1234, 0);
        push(3, 5, 0, 1, 2'b10, 16'hAB00, 0);
        push(3, 6, 0, 1, 2'b01, 16'h00CD, 0);
        // R4 miss with address bit 0 set (R11), then idle and same row (full cycle)
        push(7, 1, 1, 0, 2'b00, 16'h0, 0);
        push(7, 2, 0, 1, 2'b11, 16'h5566, 1);
        push(7, 3, 0, 0, 2'b00, 16'h0, 0);
        drain();

        // per-lane CAS style, R7
        cfg_two_cas = 1'b1;
        repeat (2) step();
        push(2, 8, 0, 0, 2'b10, 16'h0, 0);
        push(2, 9, 0, 1, 2'b11, 16'h9A9B, 0);
        push(2, 10, 0, 1, 2'b10, 16'h7700, 0);
        push(2, 11, 0, 1, 2'b01, 16'h0088, 0);
        push(2, 12, 1, 0, 2'b01, 16'h0, 0);
        push(5, 12, 0, 0, 2'b00, 16'h0, 0);
        push(5, 13, 0, 1, 2'b01, 16'h00EE, 2);
        push(6, 0, 0, 0, 2'b00, 16'h0, 0);
        push(6, 511, 0, 0, 2'b00, 16'h0, 0);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule